// File: doc/BRIEF.md
# Vector Context State Register

This block holds the 64-bit context word that a vector pipeline consults on every element-wise instruction. The word carries the maximum and current vector lengths, the source and destination element positions, the source and destination sub-element positions, five 2-bit shape selectors, a 5-bit shape enable mask, the pack and unpack ordering bits, a parallelism hint, a persistence flag for the shape mapping, and a vertical-first flag.

Three commands update it, with a fixed priority. A raw write replaces the whole word at once, as a context restore does. A set-length command loads a new maximum length, sets the current length to the smaller of a requested length and that maximum, and returns the new length on a result port. A step-advance request moves both element positions forward by one. Values that fall in the reserved ranges are rejected. The word is left as it was, and a trap output pulses.

Top module: `vec_state_reg`

## Requirements
- R1: After reset, `state_o` is all zeros, and `trap_o` and `result_vld_o` are low.
- R2: Bits are numbered MSB-first, so bit k of the layout is conventional bit 63-k of `state_o`. The conventional fields are: maxvl [63:57], vl [56:50], srcstep [49:43], dststep [42:36], dsubstep [35:34], ssubstep [33:32], five selectors [31:22] (first selector highest), enable mask [21:17], reserved [16:11], pack [10], unpack [9], hint [8:2], persistence [1] and vertical-first [0]. A legal raw write shows on `state_o` one cycle later, with the same field positions.
- R3: A legal set-length command with maximum M and request Q makes maxvl = M and vl = min(Q, M) on the next cycle. vl never exceeds maxvl.
- R4: A legal set-length command pulses `result_vld_o` for one cycle, and in that cycle `result_o` equals the new vl.
- R5: A legal raw write whose vl field is greater than its maxvl field stores vl equal to maxvl.
- R6: The reserved cases are rejected: a raw write with srcstep ≥ 64, dststep ≥ 64, vl > 64 or maxvl > 64, and a set-length command with M > 64. When one is rejected, `state_o` does not change and `trap_o` is high for the following cycle. A rejected set-length command does not pulse `result_vld_o`.
- R7: A set-length command clears the persistence bit when it changes vl or maxvl. If neither value changes, the bit is kept. It leaves every other field unchanged.
- R8: The reserved bits [16:11] always read as zero. Ones written to them are ignored.
- R9: The raw write has priority over set-length, and set-length has priority over step-advance. The highest-priority command present takes the cycle, whether it is legal or not.
- R10: A step-advance request increments srcstep and dststep independently. A step wraps to 0 when the incremented value reaches or exceeds vl. When vl is 0, both steps stay where they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Raw whole-word write request |
| wr_data | input | 64 | Word for the raw write |
| sl_en | input | 1 | Set-length command request |
| sl_mvl | input | 7 | New maximum vector length |
| sl_req | input | 7 | Requested vector length |
| step_adv | input | 1 | Advance both element steps |
| state_o | output | 64 | Current context word |
| result_o | output | 7 | Vector length from the last legal set-length command |
| result_vld_o | output | 1 | One-cycle pulse marking a new `result_o` |
| trap_o | output | 1 | One-cycle pulse after a rejected command |

## Verification
A corrupted field shows on `state_o` on the first edge after the command that caused it, because every command lands in the word in a single cycle. A wrong clamp shows as vl above maxvl, or as a `result_o` that differs from the vl field in the same cycle. A missed rejection shows as a changed word next to a raised trap. A bad persistence decision shows only in bit 1, so the sweeps compare the whole word against a word computed from the old state and the command.

// File: rtl/vst_pkg.sv
package vst_pkg;
   localparam int unsigned LEN_W  = 7;
   localparam int unsigned SUB_W  = 2;
   localparam int unsigned SEL_W  = 2;
   localparam int unsigned N_SEL  = 5;
   localparam int unsigned RSV_W  = 6;
   localparam int unsigned WORD_W = 64;

   // First member is the most significant, matching MSB-first numbering.
   typedef struct packed {
      logic [LEN_W-1:0]            maxvl;
      logic [LEN_W-1:0]            vl;
      logic [LEN_W-1:0]            srcstep;
      logic [LEN_W-1:0]            dststep;
      logic [SUB_W-1:0]            dsub;
      logic [SUB_W-1:0]            ssub;
      logic [0:N_SEL-1][SEL_W-1:0] sel;
      logic [N_SEL-1:0]            en;
      logic [RSV_W-1:0]            rsvd;
      logic                        pack;
      logic                        unpack;
      logic [LEN_W-1:0]            hint;
      logic                        persist;
      logic                        vfirst;
   } vst_t;
endpackage

// File: rtl/vst_legal_chk.sv
module vst_legal_chk
   import vst_pkg::*;
#(
   parameter int unsigned TRAP_LIMIT = 64
) (
   input  vst_t cand_i,
   output logic bad_o
);
   localparam logic [LEN_W-1:0] LIM = LEN_W'(TRAP_LIMIT);

   always_comb begin
      bad_o = (cand_i.srcstep >= LIM) || (cand_i.dststep >= LIM) ||
              (cand_i.vl > LIM)       || (cand_i.maxvl > LIM);
   end
endmodule

// File: rtl/vst_setlen.sv
module vst_setlen
   import vst_pkg::*;
#(
   parameter int unsigned TRAP_LIMIT = 64
) (
   input  vst_t             cur_i,
   input  logic [LEN_W-1:0] mvl_i,
   input  logic [LEN_W-1:0] req_i,
   output vst_t             nxt_o,
   output logic             bad_o
);
   localparam logic [LEN_W-1:0] LIM = LEN_W'(TRAP_LIMIT);

   logic [LEN_W-1:0] new_vl;

   always_comb begin
      bad_o  = (mvl_i > LIM);
      new_vl = (req_i < mvl_i) ? req_i : mvl_i;
      nxt_o       = cur_i;
      nxt_o.maxvl = mvl_i;
      nxt_o.vl    = new_vl;
      if ((new_vl != cur_i.vl) || (mvl_i != cur_i.maxvl))
         nxt_o.persist = 1'b0;
   end
endmodule

// File: rtl/vst_stepper.sv
module vst_stepper
   import vst_pkg::*;
(
   input  vst_t cur_i,
   output vst_t nxt_o
);
   localparam int unsigned N_STEP = 2;

   logic [N_STEP-1:0][LEN_W-1:0] st_cur;
   logic [N_STEP-1:0][LEN_W-1:0] st_nxt;

   assign st_cur[0] = cur_i.srcstep;
   assign st_cur[1] = cur_i.dststep;

   for (genvar g = 0; g < N_STEP; g++) begin : g_step
      logic [LEN_W:0] inc;
      assign inc = {1'b0, st_cur[g]} + 1'b1;
      always_comb begin
         if (cur_i.vl == '0)
            st_nxt[g] = st_cur[g];
         else if (inc >= {1'b0, cur_i.vl})
            st_nxt[g] = '0;
         else
            st_nxt[g] = inc[LEN_W-1:0];
      end
   end

   always_comb begin
      nxt_o         = cur_i;
      nxt_o.srcstep = st_nxt[0];
      nxt_o.dststep = st_nxt[1];
   end
endmodule

// File: rtl/vec_state_reg.sv
module vec_state_reg
   import vst_pkg::*;
#(
   parameter int unsigned TRAP_LIMIT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              sl_en,
   input  logic [LEN_W-1:0]  sl_mvl,
   input  logic [LEN_W-1:0]  sl_req,
   input  logic              step_adv,
   output logic [WORD_W-1:0] state_o,
   output logic [LEN_W-1:0]  result_o,
   output logic              result_vld_o,
   output logic              trap_o
);
   initial begin
      assert ($bits(vst_t) == WORD_W)
         else $error("context word layout must total %0d bits", WORD_W);
      assert (TRAP_LIMIT < (1 << LEN_W))
         else $error("TRAP_LIMIT must fit a length field");
   end

   vst_t cur, raw_c, raw_n, sl_n, st_n;
   logic raw_bad, sl_bad;

   assign raw_c = vst_t'(wr_data);

   vst_legal_chk #(.TRAP_LIMIT(TRAP_LIMIT)) u_raw_chk (
      .cand_i(raw_c), .bad_o(raw_bad)
   );

   always_comb begin
      raw_n      = raw_c;
      raw_n.rsvd = '0;
      if (raw_c.vl > raw_c.maxvl)
         raw_n.vl = raw_c.maxvl;
   end

   vst_setlen #(.TRAP_LIMIT(TRAP_LIMIT)) u_setlen (
      .cur_i(cur), .mvl_i(sl_mvl), .req_i(sl_req), .nxt_o(sl_n), .bad_o(sl_bad)
   );

   vst_stepper u_stepper (
      .cur_i(cur), .nxt_o(st_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur          <= '0;
         trap_o       <= 1'b0;
         result_o     <= '0;
         result_vld_o <= 1'b0;
      end else begin
         trap_o       <= 1'b0;
         result_vld_o <= 1'b0;
         if (wr_en) begin
            if (raw_bad) trap_o <= 1'b1;
            else         cur    <= raw_n;
         end else if (sl_en) begin
            if (sl_bad) begin
               trap_o <= 1'b1;
            end else begin
               cur          <= sl_n;
               result_o     <= sl_n.vl;
               result_vld_o <= 1'b1;
            end
         end else if (step_adv) begin
            cur <= st_n;
         end
      end
   end

   assign state_o = WORD_W'(cur);
endmodule

// File: rtl/vst_chk.sv
module vst_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [63:0] state_o,
   input logic [6:0]  result_o,
   input logic        result_vld_o,
   input logic        trap_o
);
   // R3: stored length never exceeds stored maximum
   a_r3_vl_within_mvl: assert property (@(posedge clk) disable iff (!rst_n)
      state_o[56:50] <= state_o[63:57]);

   // R8: reserved bits stay zero
   a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      state_o[16:11] == 6'd0);

   // R6: a trap cycle follows a cycle in which the word was kept
   a_r6_trap_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> $stable(state_o));

   // R6: a rejected command never reports a result
   a_r6_trap_no_result: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_o && result_vld_o));

   // R4: reported result matches the stored length
   a_r4_result_is_vl: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld_o |-> (result_o == state_o[56:50]));
endmodule

bind vec_state_reg vst_chk u_vst_chk (
   .clk(clk), .rst_n(rst_n), .state_o(state_o), .result_o(result_o),
   .result_vld_o(result_vld_o), .trap_o(trap_o)
);

// File: tb/test_vec_state_reg.sv
module test_vec_state_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic        sl_en = 1'b0;
   logic [6:0]  sl_mvl = '0;
   logic [6:0]  sl_req = '0;
   logic        step_adv = 1'b0;
   logic [63:0] state_o;
   logic [6:0]  result_o;
   logic        result_vld_o;
   logic        trap_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [63:0] RSV = 64'h0000_0000_0001_F800;

   always #5 clk = ~clk;

   vec_state_reg i_vec_state_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .sl_en(sl_en), .sl_mvl(sl_mvl), .sl_req(sl_req), .step_adv(step_adv),
      .state_o(state_o), .result_o(result_o), .result_vld_o(result_vld_o),
      .trap_o(trap_o)
   );

   function automatic logic [63:0] mk(input int mvl, input int vl, input int src,
                                      input int dst, input logic [3:0] sub,
                                      input logic [31:0] lo);
      return {mvl[6:0], vl[6:0], src[6:0], dst[6:0], sub, lo};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic raw(input logic [63:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic setl(input int m, input int q);
      @(negedge clk); sl_en = 1'b1; sl_mvl = m[6:0]; sl_req = q[6:0];
      @(negedge clk); sl_en = 1'b0;
   endtask

   task automatic step();
      @(negedge clk); step_adv = 1'b1;
      @(negedge clk); step_adv = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] exp, base, p;
      int          mv_list [7] = '{0, 3, 17, 63, 64, 65, 127};
      int          rw_list [5] = '{0, 9, 64, 65, 100};

      repeat (3) @(negedge clk);
      chk(state_o == 64'd0, "R1 state after reset", state_o, 64'd0);
      chk(!trap_o && !result_vld_o, "R1 flags after reset",
          {62'd0, trap_o, result_vld_o}, 64'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(state_o == 64'd0, "R1 state held after release", state_o, 64'd0);

      // R2 / R8: layout and reserved bits
      p = mk(40, 30, 12, 7, 4'hB, 32'hA5A5_FFFF);
      raw(p);
      chk(state_o == (p & ~RSV), "R2 R8 raw write image", state_o, p & ~RSV);
      chk(state_o[56:50] == 7'd30 && state_o[63:57] == 7'd40 &&
          state_o[49:43] == 7'd12 && state_o[42:36] == 7'd7,
          "R2 field positions", state_o, p);
      chk(state_o[16:11] == 6'd0, "R8 reserved read zero", state_o, 64'd0);

      // R5 / R6: raw write sweep
      exp = state_o;
      foreach (rw_list[i]) begin
         for (int v = 0; v < 128; v++) begin
            int m = rw_list[i];
            p = mk(m, v, 3, 2, 4'h0, 32'h0000_0401);
            raw(p);
            if (m > 64 || v > 64) begin
               chk(trap_o == 1'b1, "R6 raw trap raised", {63'd0, trap_o}, 64'd1);
               chk(state_o == exp, "R6 raw trap keeps state", state_o, exp);
            end else begin
               exp = mk(m, (v > m) ? m : v, 3, 2, 4'h0, 32'h0000_0401);
               chk(trap_o == 1'b0, "R6 raw no trap", {63'd0, trap_o}, 64'd0);
               chk(state_o == exp, "R5 raw truncation", state_o, exp);
            end
         end
      end
      for (int s = 58; s < 72; s++) begin
         for (int w = 0; w < 2; w++) begin
            p = (w == 0) ? mk(64, 64, s, 0, 4'h0, 32'h0) : mk(64, 64, 0, s, 4'h0, 32'h0);
            raw(p);
            if (s >= 64) begin
               chk(trap_o && state_o == exp, "R6 step out of range", state_o, exp);
            end else begin
               exp = p;
               chk(!trap_o && state_o == exp, "R6 step in range", state_o, exp);
            end
         end
      end

      // R3 / R4 / R6 / R7: set-length sweep
      foreach (mv_list[i]) begin
         for (int q = 0; q < 128; q++) begin
            int m = mv_list[i];
            int nv = (q < m) ? q : m;
            base = mk(20, 5, 2, 1, 4'h6, 32'h0040_0003);
            raw(base);
            setl(m, q);
            if (m > 64) begin
               chk(trap_o && !result_vld_o, "R6 setlen trap", {62'd0, trap_o, result_vld_o}, 64'd2);
               chk(state_o == base, "R6 setlen trap keeps state", state_o, base);
            end else begin
               logic [31:0] lo = (nv == 5 && m == 20) ? 32'h0040_0003 : 32'h0040_0001;
               exp = mk(m, nv, 2, 1, 4'h6, lo);
               chk(state_o == exp, "R3 R7 setlen word", state_o, exp);
               chk(result_vld_o && !trap_o && result_o == nv[6:0], "R4 setlen result",
                   {55'd0, result_vld_o, result_o}, {55'd0, 1'b1, nv[6:0]});
               @(negedge clk);
               chk(!result_vld_o, "R4 result pulse one cycle", {63'd0, result_vld_o}, 64'd0);
            end
         end
      end

      // R10: step advance
      raw(mk(5, 5, 0, 3, 4'h0, 32'h0));
      for (int k = 1; k <= 12; k++) begin
         step();
         exp = mk(5, 5, k % 5, (3 + k) % 5, 4'h0, 32'h0);
         chk(state_o == exp, "R10 step wrap", state_o, exp);
      end
      raw(mk(10, 4, 7, 2, 4'h0, 32'h0));
      step();
      exp = mk(10, 4, 0, 3, 4'h0, 32'h0);
      chk(state_o == exp, "R10 step beyond vl resets", state_o, exp);
      raw(mk(10, 0, 6, 9, 4'h0, 32'h0));
      step(); step();
      exp = mk(10, 0, 6, 9, 4'h0, 32'h0);
      chk(state_o == exp, "R10 zero vl holds steps", state_o, exp);

      // R9: priority
      p = mk(30, 12, 4, 4, 4'h0, 32'h0000_0002);
      @(negedge clk); wr_en = 1'b1; wr_data = p; sl_en = 1'b1; sl_mvl = 7'd8;
      sl_req = 7'd3; step_adv = 1'b1;
      @(negedge clk); wr_en = 1'b0; sl_en = 1'b0; step_adv = 1'b0;
      chk(state_o == p && !result_vld_o, "R9 raw write wins", state_o, p);
      @(negedge clk); wr_en = 1'b1; wr_data = mk(99, 1, 0, 0, 4'h0, 32'h0);
      sl_en = 1'b1; sl_mvl = 7'd8; sl_req = 7'd3; step_adv = 1'b1;
      @(negedge clk); wr_en = 1'b0; sl_en = 1'b0; step_adv = 1'b0;
      chk(state_o == p && trap_o && !result_vld_o, "R9 rejected raw write takes cycle",
          state_o, p);
      @(negedge clk); sl_en = 1'b1; sl_mvl = 7'd8; sl_req = 7'd3; step_adv = 1'b1;
      @(negedge clk); sl_en = 1'b0; step_adv = 1'b0;
      exp = mk(8, 3, 4, 4, 4'h0, 32'h0000_0000);
      chk(state_o == exp && result_o == 7'd3, "R9 setlen beats step", state_o, exp);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule